// File: doc/BRIEF.md
# Program Load and Result Readout Sequencer

This block is the host-facing sequencer that sits around a small multi-cycle processing core. It owns two on-chip memories. One is a 256-word program store with 14-bit words. The other is a 256-byte result store. A host fills the program store by holding a load strobe high and presenting one instruction word per clock. The words land at consecutive addresses, counting up from zero.

After reset the sequencer walks the whole result store and writes zero to each location. Only then does it report itself done. A start request hands control to the core with a one-cycle launch pulse. While the core runs, it fetches instructions through a registered read port and reads and writes the result store. When the core signals halt, the sequencer raises valid. A readout request then streams result bytes 0x00 to 0x0F, one per cycle, on an 8-bit output with a qualifying strobe. The done flag rises on the cycle after the last byte.

The instruction datapath itself is not part of this block. A core connects to it through the launch, run and halt signals and the memory ports.

Top module: `prog_host_seq`

## Requirements
- R1: While `load_en` is 1 and the sequencer is neither clearing nor running, each rising edge writes `load_word` to the program address held by a load counter. The counter then advances by one. The counter is 0 after reset and wraps from 255 back to 0.
- R2: `core_instr` presents the program word stored at the `core_pc` sampled on the previous rising edge (one register of latency), in any state.
- R3: After `rst_n` (active low, synchronous) is released, all 256 result locations are written to 0, one per cycle. `done` rises exactly on the 256th rising edge after release, so never before the 20th. `valid` and `done` are 0 until then.
- R4: During the clear walk, load, start, readout and core write requests have no effect. The load counter stays at 0 and no launch pulse is issued.
- R5: A start request is accepted when the sequencer is idle or holding results and `load_en` is 0. On the next edge, `core_start` is 1 for exactly one cycle, `core_run` goes to 1, and `valid` and `done` are both 0.
- R6: While `core_run` is 1, a `core_res_we` cycle writes `core_res_wdata` to `core_res_addr`. `core_res_rdata` returns the byte at the `core_res_addr` sampled on the previous edge. Core writes outside the running state are ignored.
- R7: `core_halt` sampled as 1 while running sets `valid` to 1 on the same edge and ends the run. `core_halt` in any other state is ignored.
- R8: A readout request sampled at edge E0, while `valid` is 1, no burst is in progress and `load_en` is 0, makes `out_live` 1 with `out_data` equal to result byte k after edge E0+1+k, for k = 0 to 15. `out_data` reads 0 whenever `out_live` is 0. A readout request in any other case produces no burst.
- R9: After edge E0+17, `out_live` is 0, `done` is 1 and `valid` stays 1. The results persist, so a later readout request repeats the same burst.
- R10: A start or readout request made while `load_en` is 1 is ignored.
- R11: `load_en` has no effect on the program store while the core is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; starts the clear walk |
| load_en | input | 1 | Program load strobe, one word per cycle while high |
| load_word | input | 14 | Instruction word to store |
| start_req | input | 1 | Request to launch the core |
| readout_req | input | 1 | Request to stream result bytes 0x00 to 0x0F |
| core_start | output | 1 | One-cycle launch pulse to the core (program begins at 0) |
| core_run | output | 1 | High while the core owns the result store |
| core_halt | input | 1 | Core reports it reached its halt instruction |
| core_pc | input | 8 | Program fetch address from the core |
| core_instr | output | 14 | Registered program word at the fetched address |
| core_res_we | input | 1 | Core result-store write enable |
| core_res_addr | input | 8 | Core result-store address |
| core_res_wdata | input | 8 | Core result-store write data |
| core_res_rdata | output | 8 | Registered result-store read data |
| out_data | output | 8 | Streamed result byte, 0 when not live |
| out_live | output | 1 | Qualifies `out_data` during a burst |
| valid | output | 1 | Run finished; results can be read |
| done | output | 1 | Clear walk or readout burst complete |

## Verification
A corrupted load counter shows up at the first program fetch that returns a word from the wrong slot. The sweep reads back every program address while the core runs, so a single misplaced word is caught within 256 cycles of the launch. A clear walk that stops early or runs long moves the `done` edge away from cycle 256. If it skips locations, a fresh run reads back nonzero bytes in the next burst. A burst counter or read-latency error shifts or truncates the 16-byte stream. It is seen on the very byte where the sequence departs from the expected values, or when `done` arrives one cycle off.

// File: rtl/hs_pkg.sv
// Package for the program-load / result-readout sequencer.
// Holds the controller state encoding shared by the controller and checker.
package hs_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,   // walking the result store, writing zeros
        ST_IDLE  = 3'd1,   // cleared, no results yet
        ST_RUN   = 3'd2,   // core owns the result store
        ST_READY = 3'd3,   // core halted, results held
        ST_SEND  = 3'd4,   // issuing readout addresses
        ST_TAIL  = 3'd5    // last streamed byte on the output
    } hs_state_e;

endpackage

// File: rtl/hs_sync_ram.sv
// Single-write, single-read memory with a registered read port.
// Assumes: the read returns the old contents when the read and write addresses collide.
// No reset: contents are defined only by writes.
module hs_sync_ram #(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // write port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/hs_ctrl.sv
// Sequencer controller. It runs the clear walk after reset, the program load counter,
// the start/halt handshake, the 16-byte readout burst and the status flags.
// Assumes: OUT_WORDS <= 2**RADDR_W; rst_n is synchronous and active low.
module hs_ctrl
    import hs_pkg::*;
#(
    parameter int PADDR_W   = 8,
    parameter int RADDR_W   = 8,
    parameter int OUT_WORDS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               start_req,
    input  logic               readout_req,
    input  logic               core_halt,
    output logic               prog_we,
    output logic [PADDR_W-1:0] prog_waddr,
    output logic               res_clr,
    output logic [RADDR_W-1:0] seq_addr,
    output logic               core_run,
    output logic               core_start,
    output logic               out_live,
    output logic               valid,
    output logic               done
);

    localparam logic [RADDR_W-1:0] CLR_LAST  = {RADDR_W{1'b1}};
    localparam logic [RADDR_W-1:0] SEND_LAST = RADDR_W'(OUT_WORDS - 1);

    hs_state_e          st_q, st_n;
    logic [RADDR_W-1:0] cnt_q, cnt_n;
    logic [PADDR_W-1:0] ld_addr_q;
    logic               valid_q, valid_n;
    logic               done_q, done_n;
    logic               start_q, start_n;
    logic               live_q;
    logic               start_ok, read_ok;

    // request qualification: loads block start and readout
    always_comb begin
        start_ok = start_req && !load_en && (st_q == ST_IDLE || st_q == ST_READY);
        read_ok  = readout_req && !load_en && (st_q == ST_READY);
    end

    // program write strobe: not during clear or while the core runs
    always_comb begin
        prog_we = load_en && (st_q != ST_CLEAR) && (st_q != ST_RUN);
    end

    // next-state and flag logic
    always_comb begin
        st_n    = st_q;
        cnt_n   = cnt_q;
        valid_n = valid_q;
        done_n  = done_q;
        start_n = 1'b0;
        case (st_q)
            ST_CLEAR: begin
                cnt_n = cnt_q + RADDR_W'(1);
                if (cnt_q == CLR_LAST) begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                    cnt_n  = '0;
                end
            end
            ST_IDLE: begin
                if (start_ok) begin
                    st_n    = ST_RUN;
                    start_n = 1'b1;
                    valid_n = 1'b0;
                    done_n  = 1'b0;
                end
            end
            ST_RUN: begin
                if (core_halt) begin
                    st_n    = ST_READY;
                    valid_n = 1'b1;
                end
            end
            ST_READY: begin
                if (start_ok) begin
                    st_n    = ST_RUN;
                    start_n = 1'b1;
                    valid_n = 1'b0;
                    done_n  = 1'b0;
                end else if (read_ok) begin
                    st_n   = ST_SEND;
                    cnt_n  = '0;
                    done_n = 1'b0;
                end
            end
            ST_SEND: begin
                if (cnt_q == SEND_LAST) begin
                    st_n  = ST_TAIL;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + RADDR_W'(1);
                end
            end
            ST_TAIL: begin
                st_n   = ST_READY;
                done_n = 1'b1;
            end
            default: begin
                st_n = ST_CLEAR;
            end
        endcase
    end

    // state, counter and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_CLEAR;
            cnt_q   <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            start_q <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            st_q    <= st_n;
            cnt_q   <= cnt_n;
            valid_q <= valid_n;
            done_q  <= done_n;
            start_q <= start_n;
            live_q  <= (st_q == ST_SEND);
        end
    end

    // sequential program load address, wraps at the store depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_addr_q <= '0;
        end else if (prog_we) begin
            ld_addr_q <= ld_addr_q + PADDR_W'(1);
        end
    end

    // outputs
    always_comb begin
        prog_waddr = ld_addr_q;
        res_clr    = (st_q == ST_CLEAR);
        seq_addr   = cnt_q;
        core_run   = (st_q == ST_RUN);
        core_start = start_q;
        out_live   = live_q;
        valid      = valid_q;
        done       = done_q;
    end

endmodule

// File: rtl/hs_res_arb.sv
// Result-store port arbiter. The clear walk wins the write port. The core writes
// only while it runs. The read address follows the core while it runs and the
// sequencer otherwise. The streamed output is forced to 0 outside a burst.
// Assumes: clear and run are mutually exclusive (guaranteed by the controller).
module hs_res_arb #(
    parameter int DATA_W  = 8,
    parameter int RADDR_W = 8
) (
    input  logic               res_clr,
    input  logic [RADDR_W-1:0] seq_addr,
    input  logic               core_run,
    input  logic               core_we,
    input  logic [RADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0]  core_wdata,
    input  logic [DATA_W-1:0]  mem_rdata,
    input  logic               out_live,
    output logic               mem_we,
    output logic [RADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [RADDR_W-1:0] mem_raddr,
    output logic [DATA_W-1:0]  out_data
);

    // write port selection
    always_comb begin
        if (res_clr) begin
            mem_we    = 1'b1;
            mem_waddr = seq_addr;
            mem_wdata = '0;
        end else begin
            mem_we    = core_run && core_we;
            mem_waddr = core_addr;
            mem_wdata = core_wdata;
        end
    end

    // read port selection and output gating
    always_comb begin
        mem_raddr = core_run ? core_addr : seq_addr;
        out_data  = out_live ? mem_rdata : '0;
    end

endmodule

// File: rtl/prog_host_seq.sv
// Top of the program-load and result-readout sequencer. It ties the controller,
// the two memories and the result-store arbiter together.
// Assumes: the core begins fetching at program address 0 when core_start pulses.
module prog_host_seq #(
    parameter int INSTR_W   = 14,
    parameter int DATA_W    = 8,
    parameter int PADDR_W   = 8,
    parameter int RADDR_W   = 8,
    parameter int OUT_WORDS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [INSTR_W-1:0] load_word,
    input  logic               start_req,
    input  logic               readout_req,
    output logic               core_start,
    output logic               core_run,
    input  logic               core_halt,
    input  logic [PADDR_W-1:0] core_pc,
    output logic [INSTR_W-1:0] core_instr,
    input  logic               core_res_we,
    input  logic [RADDR_W-1:0] core_res_addr,
    input  logic [DATA_W-1:0]  core_res_wdata,
    output logic [DATA_W-1:0]  core_res_rdata,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_live,
    output logic               valid,
    output logic               done
);

    logic               prog_we;
    logic [PADDR_W-1:0] prog_waddr;
    logic               res_clr;
    logic [RADDR_W-1:0] seq_addr;
    logic               mem_we;
    logic [RADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0]  mem_wdata;
    logic [RADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0]  mem_rdata;

    hs_ctrl #(
        .PADDR_W  (PADDR_W),
        .RADDR_W  (RADDR_W),
        .OUT_WORDS(OUT_WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .start_req  (start_req),
        .readout_req(readout_req),
        .core_halt  (core_halt),
        .prog_we    (prog_we),
        .prog_waddr (prog_waddr),
        .res_clr    (res_clr),
        .seq_addr   (seq_addr),
        .core_run   (core_run),
        .core_start (core_start),
        .out_live   (out_live),
        .valid      (valid),
        .done       (done)
    );

    hs_sync_ram #(
        .WIDTH (INSTR_W),
        .ADDR_W(PADDR_W)
    ) u_prog_ram (
        .clk  (clk),
        .we   (prog_we),
        .waddr(prog_waddr),
        .wdata(load_word),
        .raddr(core_pc),
        .rdata(core_instr)
    );

    hs_res_arb #(
        .DATA_W (DATA_W),
        .RADDR_W(RADDR_W)
    ) u_arb (
        .res_clr   (res_clr),
        .seq_addr  (seq_addr),
        .core_run  (core_run),
        .core_we   (core_res_we),
        .core_addr (core_res_addr),
        .core_wdata(core_res_wdata),
        .mem_rdata (mem_rdata),
        .out_live  (out_live),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .out_data  (out_data)
    );

    hs_sync_ram #(
        .WIDTH (DATA_W),
        .ADDR_W(RADDR_W)
    ) u_res_ram (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    assign core_res_rdata = mem_rdata;

endmodule

// File: rtl/prog_host_seq_chk.sv
// Protocol checker for the sequencer, bound to the top module.
// It counts cycles since reset and the length of each burst with its own counters.
module prog_host_seq_chk #(
    parameter int OUT_WORDS = 16,
    parameter int MIN_CLEAR = 20
) (
    input logic clk,
    input logic rst_n,
    input logic load_en,
    input logic core_halt,
    input logic core_start,
    input logic out_live,
    input logic valid,
    input logic done
);

    logic [15:0] since_rst;
    logic [15:0] burst_len;

    // cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 16'hFFFF) begin
            since_rst <= since_rst + 16'd1;
        end
    end

    // length of the current out_live run
    always_ff @(posedge clk) begin
        if (!rst_n || !out_live) begin
            burst_len <= '0;
        end else begin
            burst_len <= burst_len + 16'd1;
        end
    end

    AST_DONE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_rst >= 16'(MIN_CLEAR))); // R3

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R5

    AST_START_DROPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> (!valid && !done)); // R5

    AST_NO_START_DURING_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> !$past(load_en)); // R10

    AST_VALID_FROM_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(core_halt)); // R7

    AST_LIVE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_live |-> valid); // R8

    AST_BURST_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_live) |-> (burst_len == 16'(OUT_WORDS))); // R8

    AST_DONE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_live) |-> (done && valid)); // R9

endmodule

bind prog_host_seq prog_host_seq_chk #(
    .OUT_WORDS(OUT_WORDS),
    .MIN_CLEAR(20)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .core_halt (core_halt),
    .core_start(core_start),
    .out_live  (out_live),
    .valid     (valid),
    .done      (done)
);

// File: tb/prog_host_seq_bench.sv
// Self-checking bench: sweeps the whole program store, the clear walk and the readout burst.
module prog_host_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [13:0] load_word = '0;
    logic        start_req = 1'b0;
    logic        readout_req = 1'b0;
    logic        core_start;
    logic        core_run;
    logic        core_halt = 1'b0;
    logic [7:0]  core_pc = '0;
    logic [13:0] core_instr;
    logic        core_res_we = 1'b0;
    logic [7:0]  core_res_addr = '0;
    logic [7:0]  core_res_wdata = '0;
    logic [7:0]  core_res_rdata;
    logic [7:0]  out_data;
    logic        out_live;
    logic        valid;
    logic        done;

    int n_chk = 0;
    int n_fail = 0;
    int starts_seen = 0;
    int live_seen = 0;
    logic [13:0] exp_prog [256];
    logic [7:0]  exp_res [16];
    int ld_ptr = 0;

    prog_host_seq u_prog_host_seq (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_word(load_word),
        .start_req(start_req), .readout_req(readout_req),
        .core_start(core_start), .core_run(core_run), .core_halt(core_halt),
        .core_pc(core_pc), .core_instr(core_instr),
        .core_res_we(core_res_we), .core_res_addr(core_res_addr),
        .core_res_wdata(core_res_wdata), .core_res_rdata(core_res_rdata),
        .out_data(out_data), .out_live(out_live), .valid(valid), .done(done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (core_start) starts_seen++;
        if (out_live) live_seen++;
    end

    function automatic logic [13:0] word_of(int i);
        return 14'((i * 613 + 91) ^ (i << 5));
    endfunction

    function automatic logic [7:0] res_of(int a);
        return 8'(a * 29 + 3);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // reset, optionally with junk requests held during the clear walk
    task automatic do_reset(bit junk);
        int n;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 valid in reset", valid, 0);
        check("R3 done in reset", done, 0);
        starts_seen = 0;
        live_seen = 0;
        ld_ptr = 0;
        if (junk) begin
            load_en = 1'b1; load_word = 14'h3FFF;
            start_req = 1'b1; readout_req = 1'b1;
        end
        rst_n = 1'b1;
        n = 0;
        while (!done && n < 400) begin
            @(negedge clk);
            n++;
            if (n == 12) begin
                load_en = 1'b0; start_req = 1'b0; readout_req = 1'b0;
            end
            if (valid) check("R3 valid during clear", valid, 0);
        end
        check("R3 done edge count", n, 256);
        check("R4 no launch during clear", starts_seen, 0);
        check("R4 no burst during clear", live_seen, 0);
    endtask

    task automatic load_word_now(logic [13:0] w);
        load_en = 1'b1; load_word = w;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    // one accepted load: the bench tracks the expected slot
    task automatic load_one(logic [13:0] w);
        exp_prog[ld_ptr] = w;
        ld_ptr = (ld_ptr + 1) % 256;
        load_word_now(w);
    endtask

    task automatic do_start();
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        check("R5 core_start pulse", core_start, 1);
        check("R5 core_run", core_run, 1);
        check("R5 valid low", valid, 0);
        check("R5 done low", done, 0);
        @(negedge clk);
        check("R5 core_start one cycle", core_start, 0);
    endtask

    task automatic do_halt();
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        check("R7 valid after halt", valid, 1);
        check("R7 run ended", core_run, 0);
    endtask

    task automatic core_write(logic [7:0] a, logic [7:0] d);
        core_res_we = 1'b1; core_res_addr = a; core_res_wdata = d;
        @(negedge clk);
        core_res_we = 1'b0;
    endtask

    task automatic burst(string tag);
        readout_req = 1'b1;
        @(negedge clk);
        readout_req = 1'b0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            check({tag, " R8 out_live"}, out_live, 1);
            check({tag, " R8 out_data"}, out_data, exp_res[k]);
        end
        @(negedge clk);
        check({tag, " R9 live ends"}, out_live, 0);
        check({tag, " R9 done"}, done, 1);
        check({tag, " R9 valid kept"}, valid, 1);
        check({tag, " R8 data gated"}, out_data, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int b;
        // R3, R4: clear walk with junk requests held
        do_reset(1'b1);
        check("R3 valid after clear", valid, 0);

        // R7: halt outside a run is ignored
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        check("R7 halt ignored in idle", valid, 0);

        // R8: readout without results is ignored
        readout_req = 1'b1;
        @(negedge clk);
        readout_req = 1'b0;
        repeat (20) @(negedge clk);
        check("R8 no burst without valid", live_seen, 0);

        // R1: fill the store past the wrap (258 words)
        for (int i = 0; i < 258; i++) load_one(word_of(i));

        // R10: start while loading is ignored (the word itself is stored)
        start_req = 1'b1;
        exp_prog[ld_ptr] = 14'h0ABC;
        ld_ptr = (ld_ptr + 1) % 256;
        load_word_now(14'h0ABC);
        start_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 start blocked by load", starts_seen, 0);

        do_start();

        // R11: load while running is ignored
        load_word_now(14'h1234);

        // R2, R1, R11: sweep every program address through the fetch port
        for (int a = 0; a < 256; a++) begin
            core_pc = 8'(a);
            @(negedge clk);
            check("R2 program fetch", core_instr, exp_prog[a]);
        end

        // R6: core writes results and reads one back
        for (int a = 0; a < 16; a++) begin
            exp_res[a] = res_of(a);
            core_write(8'(a), res_of(a));
        end
        core_res_addr = 8'd7;
        @(negedge clk);
        check("R6 core read back", core_res_rdata, res_of(7));

        do_halt();

        // R6: write after the run is ignored
        core_write(8'd0, 8'hAA);
        // R7: halt while holding results changes nothing
        core_halt = 1'b1;
        @(negedge clk);
        core_halt = 1'b0;
        check("R7 valid stays", valid, 1);

        // R10: readout while loading is ignored
        b = live_seen;
        readout_req = 1'b1;
        exp_prog[ld_ptr] = 14'h2222;
        ld_ptr = (ld_ptr + 1) % 256;
        load_word_now(14'h2222);
        readout_req = 1'b0;
        repeat (20) @(negedge clk);
        check("R10 readout blocked by load", live_seen, b);

        burst("first");
        burst("repeat");

        // R5: a new run drops the flags; results persist
        do_start();
        do_halt();
        check("R9 done low before readout", done, 0);
        burst("rerun");

        // R3: after another reset the results read zero
        do_reset(1'b0);
        for (int a = 0; a < 16; a++) exp_res[a] = 8'h00;
        do_start();
        do_halt();
        burst("cleared");

        summary();
        $finish;
    end

endmodule